// File: doc/BRIEF.md
# Cycle-Holding Fixed-Priority Bus Arbiter

This block decides which of several bus masters owns a shared slave-side path. Each master's bus-cycle signal is its request. The block drives a one-hot grant vector. A master keeps its grant for as long as it holds its cycle signal high. A higher-priority master that starts requesting meanwhile must wait, because a running bus cycle is never cut short.

When the bus is free, or when the owner drops its cycle, the lowest-numbered requesting master wins. A build-time parameter picks one of two forms. The combinational form decides in the same cycle as the request. It costs no latency, but the priority logic sits in the request-to-grant path. The pipelined form drives the grant from a register. A new owner then sees its grant one clock after raising its cycle. After the owner releases the bus, the grant also stays on that master for one extra clock.

Synchronous active-high reset clears the stored owner. A build with a single master ties that master's grant permanently high.

Top module: `cyc_hold_arbiter`

## Requirements
- R1: The grant vector is one-hot or all zeros in every cycle, in both forms.
- R2: A clock edge with `rst` high clears the stored owner. In the pipelined form, grant is all zeros in the cycle after such an edge. In the combinational form, grant during reset is just the priority pick of the present requests.
- R3: With no request, the combinational form drives zero grant in the same cycle. The pipelined form drives zero grant from the next cycle on.
- R4: With no current owner, the requester with the lowest index is granted. Bit i of `cyc_req` and bit i of `grant` both belong to master i.
- R5: While the owner keeps its request bit high, its grant stays unchanged, even when a lower-indexed master also requests.
- R6: In the combinational form, a request from an idle bus is granted in the same cycle it is raised.
- R7: In the pipelined form, a request from an idle bus is granted one clock after it is raised, and grant is zero in the cycle it is raised.
- R8: When the owner drops its request, the lowest-indexed remaining requester takes over. In the combinational form this happens in the same cycle. In the pipelined form it happens one clock later, and the previous grant persists for that one cycle.
- R9: The combinational form never grants a master whose request is low in that cycle. The pipelined form never grants a master that was not requesting in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_req | input | NUM_MASTERS | Bus-cycle signal of each master, used as its request |
| grant | output | NUM_MASTERS | One-hot grant, bit i for master i |

## Verification
The bench runs one instance of each form side by side and drives them with the same requests. The sharpest case is a lower-indexed master raising its request while a higher-indexed owner is still active. A design that re-arbitrates every cycle would steal the bus there and break R5. The hand-over after the owner releases is checked in both forms. A combinational form that waits for the register would lose its zero-latency property. A pipelined form that switches early would let the grant output change without a register stage. Reset with requests present and the idle-to-request edge are also covered. These catch a pipelined form whose grant leaks through combinationally, and a stored owner that survives reset.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
    // Which grant path the arbiter is built with
    typedef enum logic {
        ARB_COMB = 1'b0,   // grant decided in the cycle of the request
        ARB_PIPE = 1'b1    // grant taken from a register, one cycle later
    } arb_form_e;
endpackage

// File: rtl/arb_prio_pick.sv
`timescale 1ns/1ps
// Fixed priority pick: the lowest set index wins (R4)
module arb_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic [N:0] blocked;   // blocked[i]: some index below i is set

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign pick[i]        = req[i] & ~blocked[i];
        assign blocked[i + 1] = blocked[i] | req[i];
    end
endmodule

// File: rtl/arb_grant_path.sv
`timescale 1ns/1ps
// Owner register plus the form-specific grant path
module arb_grant_path
    import arb_pkg::*;
#(
    parameter int        N    = 4,
    parameter arb_form_e FORM = ARB_COMB
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] pick,
    output logic [N-1:0] grant
);
    typedef struct packed {
        logic [N-1:0] owner;
    } own_state_t;

    own_state_t st_d, st_q;
    logic       held;      // the stored owner still holds its cycle

    assign held = |(req & st_q.owner);

    if (FORM == ARB_COMB) begin : g_comb
        logic [N-1:0] eff_grant;
        always_comb begin
            eff_grant  = held ? st_q.owner : pick;
            st_d.owner = eff_grant;
        end
        assign grant = eff_grant;
    end else begin : g_pipe
        always_comb begin
            st_d.owner = held ? st_q.owner : pick;
        end
        assign grant = st_q.owner;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cyc_hold_arbiter.sv
`timescale 1ns/1ps
module cyc_hold_arbiter
    import arb_pkg::*;
#(
    parameter int        NUM_MASTERS = 4,
    parameter arb_form_e FORM        = ARB_COMB
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] cyc_req,
    output logic [NUM_MASTERS-1:0] grant
);
    localparam bit SINGLE = (NUM_MASTERS == 1);

    if (SINGLE) begin : g_single
        // the only master always owns the path
        assign grant = '1;
    end else begin : g_multi
        logic [NUM_MASTERS-1:0] pick;

        arb_prio_pick #(
            .N (NUM_MASTERS)
        ) u_pick (
            .req  (cyc_req),
            .pick (pick)
        );

        arb_grant_path #(
            .N    (NUM_MASTERS),
            .FORM (FORM)
        ) u_path (
            .clk   (clk),
            .rst   (rst),
            .req   (cyc_req),
            .pick  (pick),
            .grant (grant)
        );
    end
endmodule

// File: rtl/cyc_hold_arbiter_chk.sv
`timescale 1ns/1ps
module cyc_hold_arbiter_chk
    import arb_pkg::*;
#(
    parameter int        N    = 4,
    parameter arb_form_e FORM = ARB_COMB
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] cyc_req,
    input logic [N-1:0] grant
);
    if (N > 1) begin : g_chk
        assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant));

        assert_hold_owner_R5: assert property (@(posedge clk) disable iff (rst)
            (|(grant & cyc_req)) |=>
                ((|($past(grant) & cyc_req)) -> (grant == $past(grant))));

        if (FORM == ARB_COMB) begin : g_comb
            assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
                (cyc_req == '0) |-> (grant == '0));

            assert_no_stray_grant_R9: assert property (@(posedge clk) disable iff (rst)
                (grant & ~cyc_req) == '0);

            assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((($past(grant) & cyc_req) == '0) ->
                          (grant == (cyc_req & (~cyc_req + 1'b1)))));
        end else begin : g_pipe
            assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
                (cyc_req == '0) |=> (grant == '0));

            assert_no_stray_grant_R9: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((grant & ~$past(cyc_req)) == '0));

            assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
                ((grant & cyc_req) == '0) |=>
                    (grant == $past(cyc_req & (~cyc_req + 1'b1))));
        end
    end
endmodule

bind cyc_hold_arbiter cyc_hold_arbiter_chk #(
    .N    (NUM_MASTERS),
    .FORM (FORM)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cyc_req (cyc_req),
    .grant   (grant)
);

// File: tb/cyc_hold_arbiter_tb.sv
`timescale 1ns/1ps
module cyc_hold_arbiter_tb;
    import arb_pkg::*;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] grant_c, grant_p;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference owners, -1 means none
    int own_c = -1;
    int own_p = -1;

    always #2 clk = ~clk;   // 250 MHz

    cyc_hold_arbiter #(.NUM_MASTERS(N), .FORM(ARB_COMB)) u_dut (
        .clk(clk), .rst(rst), .cyc_req(req), .grant(grant_c));

    cyc_hold_arbiter #(.NUM_MASTERS(N), .FORM(ARB_PIPE)) u_dut_pipe (
        .clk(clk), .rst(rst), .cyc_req(req), .grant(grant_p));

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] as_vec(input int idx);
        logic [N-1:0] v = '0;
        if (idx >= 0) v[idx] = 1'b1;
        return v;
    endfunction

    function automatic int comb_choice(input int owner, input logic [N-1:0] r);
        if (owner >= 0 && r[owner]) return owner;
        return lowest(r);
    endfunction

    // reference model advances on every edge
    always @(posedge clk) begin
        if (rst) begin
            own_c <= -1;
            own_p <= -1;
        end else begin
            own_c <= comb_choice(own_c, req);
            own_p <= comb_choice(own_p, req);
        end
    end

    task automatic check(input string tag, input string form,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s form=%s actual=%b expected=%b", tag, form, act, exp);
        end
    endtask

    // drive one cycle of requests and compare both forms
    task automatic step(input logic [N-1:0] r, input string tag);
        @(negedge clk);
        req = r;
        #1;
        check(tag, "comb", grant_c, as_vec(comb_choice(own_c, req)));
        check(tag, "pipe", grant_p, as_vec(own_p));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R2: reset with requests present
        step(4'b0110, "R2");
        step(4'b0110, "R2");
        rst = 1'b0;
        // R3: idle bus
        step(4'b0000, "R3");
        step(4'b0000, "R3");
        // R6 / R7: request from idle, R4 lowest wins
        step(4'b1010, "R6");
        step(4'b1010, "R7");
        step(4'b1010, "R4");
        // R5: higher priority arrives while owner holds
        step(4'b1011, "R5");
        step(4'b1011, "R5");
        step(4'b1111, "R5");
        // R8: owner releases, hand-over
        step(4'b1001, "R8");
        step(4'b1001, "R8");
        // R9: owner drops, grant must follow live requests
        step(4'b1000, "R9");
        step(4'b1000, "R9");
        step(4'b0000, "R3");
        step(4'b0000, "R3");
        // R1: pseudo-random request patterns
        begin
            logic [7:0] lf = 8'hA5;
            for (int k = 0; k < 300; k++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                step(lf[3:0] & {N{lf[7] | lf[6]}}, "R1");
                checks++;
                if (!$onehot0(grant_c) || !$onehot0(grant_p)) begin
                    fails++;
                    $display("FAIL R1 actual=%b/%b expected=one-hot or zero",
                             grant_c, grant_p);
                end
            end
        end
        // R2: reset mid-ownership clears stored owner
        step(4'b0100, "R2");
        rst = 1'b1;
        step(4'b0100, "R2");
        step(4'b0000, "R2");
        rst = 1'b0;
        step(4'b0000, "R3");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule